// File: doc/BRIEF.md
# Clause 22 MDIO Management Master

This block is a register-driven station management master for IEEE 802.3 Clause 22 PHY access. Software places a 16-bit value in the data word, then writes a command word that names the PHY, the register, the direction and an MDC divider code, with the start bit set. The block then produces MDC from the system clock and runs one 64-bit management frame on MDIO. It drives the line through an output-enable pin and samples it on the way back in.

The start bit doubles as a busy flag. It reads 1 until the frame has finished. After a read, the 16 bits returned by the PHY sit in the data word. A command write with the start bit clear sends no frame. It produces one bare MDC period instead, which some PHYs need to leave reset. A command write that arrives while the block is working is dropped.

Top module: `mdio_ctrl`

## Requirements
- R1: After reset both words read 0, `mdc` is low and `mdio_oe` is low.
- R2: Command word (bus_addr=0) layout: bit 0 start/busy, bit 1 direction (1 write, 0 read), bits 5:2 divider code, bits 10:6 register number, bits 15:11 PHY address. Bits 31:16 read as 0. The accepted fields read back unchanged.
- R3: A command write with bit 0 set makes bit 0 read 1 for the whole frame, and 0 once the final MDC falling edge has occurred.
- R4: A write frame is, MSB first: 32 ones, 01, opcode 01, PHY address, register number, turnaround 10, then the 16 data bits. `mdio_oe` is high for all 64 bits.
- R5: A read frame is, MSB first: 32 ones, 01, opcode 10, PHY address, register number. `mdio_oe` is high for these first 46 bits and low for the remaining 18 bits (turnaround and data).
- R6: During a read, the 16 data bits are sampled on the MDC rising edges of bits 48 to 63, MSB first. Once busy has cleared, they appear in bits 15:0 of the data word (bus_addr=1), with bits 31:16 zero.
- R7: `mdio_o` changes only when MDC falls, never while MDC is high. The first frame bit is driven before the first MDC rising edge.
- R8: One MDC period lasts a number of system clocks set by the divider code: code 0 gives 42, 1 gives 62, 2 gives 16, 3 gives 26, 4 gives 102, 5 gives 124, and codes 6 to 15 give 124. MDC is high for half of each period.
- R9: A command write made while busy is 1 is ignored. The running frame and the stored command fields are unchanged.
- R10: A command write with bit 0 clear, made while the block is idle, produces exactly one MDC pulse. `mdio_oe` stays low and busy stays 0.
- R11: A write frame sends bits 15:0 of the data word as it was when the command was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 1 | Word select: 0 command word, 1 data word |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Contents of the selected word (combinational) |
| mdc | output | 1 | Management clock to the PHY |
| mdio_i | input | 1 | Sampled level of the MDIO line |
| mdio_o | output | 1 | Value driven onto MDIO |
| mdio_oe | output | 1 | Drive enable for MDIO |

## Verification
If the bit counter or shift register is wrong, the error shows up in the bit stream on the MDC rising edges. It also shows up as a turnaround where the enable falls at the wrong bit. Either one appears within the same frame. A divider that is off shows up as an MDC period that does not match the code, measured between the first two rising edges. A broken busy interlock shows up when busy clears early, when a dropped command changes the fields that read back, or when a bare MDC pulse leaks drive onto MDIO. Read data that is shifted wrongly shows up as a wrong data word as soon as busy has cleared.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int FRAME_BITS = 64;
    localparam int CNT_W      = $clog2(FRAME_BITS);
    localparam int HALF_W     = 7;
    localparam int PRE_BITS   = 32;
    localparam int TA_IDX     = 46;   // first turnaround bit
    localparam int RXD_IDX    = 48;   // first read data bit

    typedef struct packed {
        logic [4:0] phy;
        logic [4:0] regn;
        logic [3:0] code;
        logic       wr;
    } mdio_cmd_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FRAME,
        ST_PULSE
    } mdio_state_t;

    // Full MDC period in system clocks for a divider code.
    function automatic int unsigned div_of(input logic [3:0] code);
        case (code)
            4'd0:    return 42;
            4'd1:    return 62;
            4'd2:    return 16;
            4'd3:    return 26;
            4'd4:    return 102;
            4'd5:    return 124;
            default: return 124;
        endcase
    endfunction

    function automatic logic [HALF_W-1:0] half_of(input logic [3:0] code);
        int unsigned d;
        d = div_of(code);
        return HALF_W'(d / 2);
    endfunction

    function automatic logic [FRAME_BITS-1:0] build_frame(
        input mdio_cmd_t c, input logic [15:0] wd);
        logic [1:0] op;
        logic [1:0] ta;
        op = c.wr ? 2'b01 : 2'b10;
        ta = c.wr ? 2'b10 : 2'b11;
        return {{PRE_BITS{1'b1}}, 2'b01, op, c.phy, c.regn, ta, wd};
    endfunction

endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic [3:0]        code,
    output logic              mdc,
    output logic              rise,
    output logic              fall
);
    logic [HALF_W-1:0] cnt_q;
    logic [HALF_W-1:0] half;
    logic              tick;

    assign half = half_of(code);
    assign tick = run && (cnt_q == half - HALF_W'(1));
    assign rise = tick && !mdc;
    assign fall = tick && mdc;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
            mdc   <= 1'b0;
        end else if (tick) begin
            cnt_q <= '0;
            mdc   <= ~mdc;
        end else begin
            cnt_q <= cnt_q + HALF_W'(1);
        end
    end
endmodule

// File: rtl/mdio_shifter.sv
module mdio_shifter
    import mdio_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        go_frame,
    input  logic        go_pulse,
    input  mdio_cmd_t   cmd,
    input  logic [15:0] wdata,
    input  logic        rise,
    input  logic        fall,
    input  logic        mdio_i,
    output logic        run,
    output logic        active,
    output logic        mdio_o,
    output logic        mdio_oe,
    output logic        done,
    output logic [15:0] rx
);
    mdio_state_t           st_q;
    logic [FRAME_BITS-1:0] sh_q;
    logic [CNT_W-1:0]      idx_q;
    logic                  wr_q;
    logic                  last;

    assign last    = (idx_q == CNT_W'(FRAME_BITS - 1));
    assign run     = (st_q != ST_IDLE);
    assign active  = run;
    assign done    = (st_q == ST_FRAME) && fall && last;
    assign mdio_o  = (st_q == ST_FRAME) ? sh_q[FRAME_BITS-1] : 1'b1;
    assign mdio_oe = (st_q == ST_FRAME) && (wr_q || (idx_q < CNT_W'(TA_IDX)));

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            sh_q  <= '0;
            idx_q <= '0;
            wr_q  <= 1'b0;
            rx    <= '0;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (go_frame) begin
                        st_q  <= ST_FRAME;
                        sh_q  <= build_frame(cmd, wdata);
                        idx_q <= '0;
                        wr_q  <= cmd.wr;
                    end else if (go_pulse) begin
                        st_q <= ST_PULSE;
                    end
                end
                ST_FRAME: begin
                    if (rise && !wr_q && (idx_q >= CNT_W'(RXD_IDX)))
                        rx <= {rx[14:0], mdio_i};
                    if (fall) begin
                        if (last) begin
                            st_q <= ST_IDLE;
                        end else begin
                            idx_q <= idx_q + CNT_W'(1);
                            sh_q  <= {sh_q[FRAME_BITS-2:0], 1'b1};
                        end
                    end
                end
                ST_PULSE: begin
                    if (fall)
                        st_q <= ST_IDLE;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/mdio_regs.sv
module mdio_regs
    import mdio_pkg::*;
#(
    parameter int REG_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_wr,
    input  logic             bus_addr,
    input  logic [REG_W-1:0] bus_wdata,
    output logic [REG_W-1:0] bus_rdata,
    input  logic             active,
    input  logic             done,
    input  logic [15:0]      rx,
    output mdio_cmd_t        cmd,
    output logic [15:0]      data_q,
    output logic             busy,
    output logic             go_frame,
    output logic             go_pulse
);
    logic       locked;
    logic       cmd_acc;
    logic [15:0] cmd_word;
    logic       unused_hi;

    assign unused_hi = ^bus_wdata[REG_W-1:16];
    assign locked    = busy || active || go_frame || go_pulse;
    assign cmd_acc   = bus_wr && !bus_addr && !locked;
    assign cmd_word  = {cmd.phy, cmd.regn, cmd.code, cmd.wr, busy};
    assign bus_rdata = bus_addr ? {{(REG_W-16){1'b0}}, data_q}
                                : {{(REG_W-16){1'b0}}, cmd_word};

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd      <= '0;
            data_q   <= '0;
            busy     <= 1'b0;
            go_frame <= 1'b0;
            go_pulse <= 1'b0;
        end else begin
            go_frame <= cmd_acc && bus_wdata[0];
            go_pulse <= cmd_acc && !bus_wdata[0];
            if (cmd_acc) begin
                cmd.phy  <= bus_wdata[15:11];
                cmd.regn <= bus_wdata[10:6];
                cmd.code <= bus_wdata[5:2];
                cmd.wr   <= bus_wdata[1];
                busy     <= bus_wdata[0];
            end else if (done) begin
                busy <= 1'b0;
            end
            if (done && !cmd.wr)
                data_q <= rx;
            else if (bus_wr && bus_addr)
                data_q <= bus_wdata[15:0];
        end
    end
endmodule

// File: rtl/mdio_ctrl.sv
module mdio_ctrl
    import mdio_pkg::*;
#(
    parameter int REG_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_wr,
    input  logic             bus_addr,
    input  logic [REG_W-1:0] bus_wdata,
    output logic [REG_W-1:0] bus_rdata,
    output logic             mdc,
    input  logic             mdio_i,
    output logic             mdio_o,
    output logic             mdio_oe
);
    mdio_cmd_t   cmd;
    logic [15:0] data_q;
    logic [15:0] rx;
    logic        busy;
    logic        go_frame;
    logic        go_pulse;
    logic        active;
    logic        done;
    logic        run;
    logic        rise;
    logic        fall;

    mdio_regs #(.REG_W(REG_W)) u_regs (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .active(active),
        .done(done), .rx(rx), .cmd(cmd), .data_q(data_q), .busy(busy),
        .go_frame(go_frame), .go_pulse(go_pulse)
    );

    mdio_clkgen u_clk (
        .clk(clk), .rst(rst), .run(run), .code(cmd.code),
        .mdc(mdc), .rise(rise), .fall(fall)
    );

    mdio_shifter u_shf (
        .clk(clk), .rst(rst), .go_frame(go_frame), .go_pulse(go_pulse),
        .cmd(cmd), .wdata(data_q), .rise(rise), .fall(fall),
        .mdio_i(mdio_i), .run(run), .active(active), .mdio_o(mdio_o),
        .mdio_oe(mdio_oe), .done(done), .rx(rx)
    );
endmodule

// File: rtl/mdio_ctrl_chk.sv
module mdio_ctrl_chk (
    input logic        clk,
    input logic        rst,
    input logic        mdc,
    input logic        mdio_o,
    input logic        mdio_oe,
    input logic        busy,
    input logic        bus_wr,
    input logic        bus_addr,
    input logic [15:0] cmd_bits
);
    // R5
    oe_in_frame_chk: assert property (@(posedge clk) disable iff (rst)
        mdio_oe |-> busy);

    // R7
    out_steady_high_chk: assert property (@(posedge clk) disable iff (rst)
        (mdc && $past(mdc)) |-> $stable(mdio_o));

    // R8
    mdc_min_high_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(mdc) |=> mdc);

    // R9
    busy_cmd_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && bus_wr && !bus_addr) |=> $stable(cmd_bits));

    // R3
    busy_end_low_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> !mdc);
endmodule

bind mdio_ctrl mdio_ctrl_chk u_chk (
    .clk(clk), .rst(rst), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .busy(busy), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .cmd_bits({cmd.phy, cmd.regn, cmd.code, cmd.wr, 1'b0})
);

// File: tb/test_mdio_ctrl.sv
module test_mdio_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic        bus_addr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        mdc, mdio_o, mdio_oe, mdio_i;
    logic        phy_drv = 1'b1;
    int          total = 0;
    int          bad = 0;

    assign mdio_i = mdio_oe ? mdio_o : phy_drv;

    always #5 clk = ~clk;

    mdio_ctrl i_mdio_ctrl (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc),
        .mdio_i(mdio_i), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
    );

    // {wr, phy, reg, code, data}
    localparam logic [30:0] VEC [6] = '{
        {1'b1, 5'd1,  5'd0,  4'd2, 16'hA5C3},
        {1'b0, 5'd3,  5'd2,  4'd3, 16'h1234},
        {1'b1, 5'd31, 5'd31, 4'd0, 16'h8001},
        {1'b0, 5'd0,  5'd17, 4'd1, 16'hFFFE},
        {1'b1, 5'd10, 5'd5,  4'd9, 16'h0F0F},
        {1'b0, 5'd21, 5'd9,  4'd4, 16'h6DB7}
    };

    function automatic int exp_div(input logic [3:0] c);
        if (c == 4'd0) return 42;
        if (c == 4'd1) return 62;
        if (c == 4'd2) return 16;
        if (c == 4'd3) return 26;
        if (c == 4'd4) return 102;
        return 124;
    endfunction

    task automatic chk(input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    // Run one frame, observe it bit by bit, emulate a PHY answer.
    task automatic run_frame(input logic wr, input logic [4:0] phy,
                             input logic [4:0] rg, input logic [3:0] code,
                             input logic [15:0] d, input logic intrude);
        logic [63:0] exp_f, got_f, got_oe, exp_oe;
        logic [31:0] r;
        logic [15:0] cw;
        time t0, t1;
        cw = {phy, rg, code, wr, 1'b1};
        exp_f  = {32'hFFFF_FFFF, 2'b01, (wr ? 2'b01 : 2'b10), phy, rg,
                  (wr ? 2'b10 : 2'b00), (wr ? d : 16'h0000)};
        exp_oe = wr ? {64{1'b1}} : {{46{1'b1}}, 18'h0};
        if (wr) bus_write(1'b1, {16'hDEAD, d});
        bus_write(1'b0, {16'h0, cw});
        got_f = '0; got_oe = '0; t0 = 0; t1 = 0;
        phy_drv = 1'b1;
        for (int i = 0; i < 64; i++) begin
            @(posedge mdc);
            if (i == 0) t0 = $time;
            if (i == 1) t1 = $time;
            got_oe[63-i] = mdio_oe;
            got_f[63-i]  = mdio_oe ? mdio_o : 1'b0;
            if (i == 32) begin
                bus_read(1'b0, r);
                chk("R3 busy during frame", {63'h0, r[0]}, 64'h1);
            end
            if (intrude && i == 10)
                bus_write(1'b0, 32'h0000_FFFF);
            @(negedge mdc);
            if (!wr && i + 1 == 47) phy_drv = 1'b0;
            else if (!wr && i + 1 >= 48 && i + 1 <= 63) phy_drv = d[62-i];
            else phy_drv = 1'b1;
        end
        if (!wr) got_f[15:0] = 16'h0000;
        chk(wr ? "R4 write frame bits" : "R5 read frame bits", got_f, exp_f);
        chk(wr ? "R4 write drive enable" : "R5 read release", got_oe, exp_oe);
        chk("R8 mdc period", 64'((t1 - t0) / 10), 64'(exp_div(code)));
        repeat (2) @(negedge clk);
        bus_read(1'b0, r);
        chk("R3 busy cleared", {63'h0, r[0]}, 64'h0);
        chk("R2 command readback", 64'(r), 64'({16'h0, cw[15:1], 1'b0}));
        if (!wr) begin
            bus_read(1'b1, r);
            chk("R6 read data word", 64'(r), 64'({16'h0, d}));
        end
    endtask

    initial begin
        #(10 * 150000);
        bad++; total++;
        $display("FAIL watchdog act=timeout exp=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] r;
        int rises;
        logic oe_seen;
        logic prev_mdc;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        // R1
        bus_read(1'b0, r); chk("R1 command word reset", 64'(r), 64'h0);
        bus_read(1'b1, r); chk("R1 data word reset", 64'(r), 64'h0);
        chk("R1 mdc and oe reset", {62'h0, mdc, mdio_oe}, 64'h0);

        // Table walk (R4, R5, R6, R8, R11)
        foreach (VEC[k])
            run_frame(VEC[k][30], VEC[k][29:25], VEC[k][24:20],
                      VEC[k][19:16], VEC[k][15:0], 1'b0);

        // R9: a command written mid-frame is dropped
        run_frame(1'b1, 5'd7, 5'd12, 4'd2, 16'h3C3C, 1'b1);

        // R11: data word value at command time goes out (checked above); confirm word kept
        bus_read(1'b1, r);
        chk("R11 data word kept after write frame", 64'(r), 64'h3C3C);

        // R10: command with start clear gives one MDC pulse, no drive
        bus_write(1'b0, 32'h0000_0008);
        rises = 0; oe_seen = 1'b0; prev_mdc = 1'b0;
        for (int c = 0; c < 300; c++) begin
            @(negedge clk);
            if (mdc && !prev_mdc) rises++;
            prev_mdc = mdc;
            if (mdio_oe) oe_seen = 1'b1;
            if (bus_rdata[0] && !bus_addr) oe_seen = 1'b1;
        end
        chk("R10 single mdc pulse", 64'(rises), 64'h1);
        chk("R10 no drive and no busy", {63'h0, oe_seen}, 64'h0);
        bus_read(1'b0, r);
        chk("R2 fields from start-clear write", 64'(r), 64'h0000_0008);

        // R7 first bit present before first rise: checked via frame bit 63 above
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule